// File: doc/BRIEF.md
# Byte-Window Read Adapter

The adapter turns a byte-addressed read request into reads on a port that only returns whole words. A request gives a signed byte offset and a signed byte length. Both are relative to a fixed region of the word store. The adapter first checks the request against the region size. It then shifts the request by a fixed region base, works out which words cover the requested bytes, and fetches them one at a time. Only the requested bytes leave the block, in address order.

A request that is out of range or has no length is refused with an error pulse, and no word is fetched. A fetch that the word port reports as failed ends the request with an error pulse. The bytes already sent stay valid. Only one request is handled at a time, and `req_ready` is high only when the adapter is idle. Setting `WORD_BYTES` to 1 turns the block into a plain byte-by-byte reader with no word translation.

Top module: `byte_window_reader`

## Requirements
- R1: A request whose offset is negative is refused. The adapter pulses `resp_err` one cycle after acceptance, issues no word read and emits no byte.
- R2: A request whose size is zero or negative is refused in the same way as R1.
- R3: A request is refused as in R1 when offset plus size exceeds `REGION_SIZE`. A request that ends exactly at `REGION_SIZE` is accepted.
- R4: The first word read has index (offset + `REGION_BASE`) / `WORD_BYTES`, and no read index falls outside the words of the region.
- R5: An accepted request reads exactly ceil((offset + `REGION_BASE` + size) / `WORD_BYTES`) minus the first index words, with indices rising by one.
- R6: Word byte lane k (bits 8k+7..8k) holds the byte at address index*`WORD_BYTES`+k. Output bytes start at lane (offset + `REGION_BASE`) mod `WORD_BYTES` of the first word, follow in rising address order, number exactly size, and only the final byte has `out_last` high.
- R7: `resp_done` pulses for one cycle in the cycle after the byte marked `out_last`. It never coincides with `resp_err`.
- R8: A word read returned with `rd_err` high aborts the request. `resp_err` pulses in the next cycle, and no further byte, word read or `resp_done` follows for that request.
- R9: `req_ready` is high only while idle. A `req_valid` pulse while busy is ignored: it yields no response, read or byte.
- R10: `rd_req` stays high with a stable `rd_idx` until `rd_ack` is seen, and `rd_req` and `out_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Adapter idle and able to take a request |
| req_offset | input | ADDR_W (12) | Signed byte offset into the region |
| req_size | input | ADDR_W (12) | Signed byte count |
| rd_req | output | 1 | Word read request, held until acknowledged |
| rd_idx | output | IDX_W (6) | Word index of the read |
| rd_ack | input | 1 | Word read completed this cycle |
| rd_data | input | 8*WORD_BYTES (32) | Word returned with `rd_ack`, lane 0 lowest |
| rd_err | input | 1 | Word read failed, qualified by `rd_ack` |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the request |
| resp_done | output | 1 | Request completed without error |
| resp_err | output | 1 | Request refused or aborted |

## Verification
The bound checker runs on every cycle. It checks the word-port handshake, keeps `rd_idx` inside the region, and checks that no read is issued once the word budget is spent. It also checks that the last byte is followed by `resp_done`, that a failed read is followed by `resp_err`, and that the adapter is never busy with `req_ready` high. Only the scoreboard scenarios can show the arithmetic. That covers the exact first index and word count for unaligned windows, the lane where output starts, byte values and order, and the exact edges of the bounds check. The scoreboard is also needed to show that a spurious request while busy leaves no trace.

// File: rtl/bwr_pkg.sv
// Shared definitions for the byte-window read adapter.
// Assumes: nothing beyond IEEE 1800-2017.
package bwr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        BWR_IDLE  = 2'd0,
        BWR_FETCH = 2'd1,
        BWR_EMIT  = 2'd2
    } bwr_state_e;

endpackage

// File: rtl/bwr_span_calc.sv
// Validates a byte window and maps it onto word indices.
// Assumes: WORD_BYTES is a power of two and ADDR_W can hold
// REGION_BASE + REGION_SIZE as a positive signed value.
module bwr_span_calc #(
    parameter int WORD_BYTES  = 4,
    parameter int REGION_BASE = 96,
    parameter int REGION_SIZE = 32,
    parameter int ADDR_W      = 12,
    parameter int IDX_W       = 6,
    parameter int LANE_W      = 2,
    parameter int CNT_W       = 6
) (
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W-1:0] size_i,
    output logic              ok_o,
    output logic [IDX_W-1:0]  first_idx_o,
    output logic [IDX_W-1:0]  word_cnt_o,
    output logic [LANE_W-1:0] lane_o,
    output logic [CNT_W-1:0]  byte_cnt_o
);
    localparam int SUM_W = ADDR_W + 2;
    localparam int SH    = $clog2(WORD_BYTES);
    localparam logic signed [SUM_W-1:0] RSIZE_S = SUM_W'(REGION_SIZE);
    localparam logic signed [SUM_W-1:0] BASE_S  = SUM_W'(REGION_BASE);
    localparam logic signed [SUM_W-1:0] WBM1_S  = SUM_W'(WORD_BYTES - 1);

    logic signed [SUM_W-1:0] off_x;
    logic signed [SUM_W-1:0] size_x;
    logic signed [SUM_W-1:0] end_x;
    logic signed [SUM_W-1:0] adj_x;
    logic signed [SUM_W-1:0] bound_x;
    logic        [SUM_W-1:0] adj_u;
    logic        [SUM_W-1:0] bound_u;
    logic        [SUM_W-1:0] first_full;
    logic        [SUM_W-1:0] bound_full;

    // Sign-extend the operands and form the window end, adjusted start and rounded-up bound.
    always_comb begin
        off_x   = {{2{offset_i[ADDR_W-1]}}, offset_i};
        size_x  = {{2{size_i[ADDR_W-1]}}, size_i};
        end_x   = off_x + size_x;
        adj_x   = off_x + BASE_S;
        bound_x = adj_x + size_x + WBM1_S;
        adj_u   = adj_x;
        bound_u = bound_x;
    end

    // Accept only a non-negative start, a positive length and a window inside the region.
    always_comb begin
        ok_o = (off_x >= 0) && (size_x > 0) && (end_x <= RSIZE_S);
    end

    // Divide by the word size with shifts; the remainder gives the starting lane.
    always_comb begin
        first_full  = adj_u >> SH;
        bound_full  = bound_u >> SH;
        first_idx_o = first_full[IDX_W-1:0];
        word_cnt_o  = bound_full[IDX_W-1:0] - first_full[IDX_W-1:0];
        byte_cnt_o  = size_x[CNT_W-1:0];
    end

    generate
        if (SH == 0) begin : g_byte_wide
            // One-byte words: every access starts at lane zero.
            always_comb lane_o = '0;
        end else begin : g_multi_byte
            // Lane is the low address bits of the adjusted start.
            always_comb lane_o = adj_u[LANE_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/bwr_lane_mux.sv
// Picks one byte lane out of a fetched word.
// Assumes: lane 0 is the least significant byte (little-endian order).
module bwr_lane_mux #(
    parameter int WORD_BYTES = 4,
    parameter int LANE_W     = 2
) (
    input  logic [8*WORD_BYTES-1:0] word_i,
    input  logic [LANE_W-1:0]       lane_i,
    output logic [7:0]              byte_o
);
    generate
        if (WORD_BYTES == 1) begin : g_pass
            logic unused_lane;
            // A single-byte word is passed through unchanged.
            always_comb begin
                byte_o      = word_i;
                unused_lane = |lane_i;
            end
        end else begin : g_select
            // Indexed part-select of the addressed lane.
            always_comb byte_o = word_i[32'(lane_i) * 8 +: 8];
        end
    endgenerate

endmodule

// File: rtl/bwr_fetch_ctrl.sv
// Sequencer: accepts a request, fetches words one by one and walks their lanes.
// Assumes: the word port acknowledges each held request exactly once, and
// the byte consumer needs no backpressure.
module bwr_fetch_ctrl
    import bwr_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int IDX_W      = 6,
    parameter int LANE_W     = 2,
    parameter int CNT_W      = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid_i,
    input  logic                    span_ok_i,
    input  logic [IDX_W-1:0]        first_idx_i,
    input  logic [IDX_W-1:0]        word_cnt_i,
    input  logic [LANE_W-1:0]       lane_i,
    input  logic [CNT_W-1:0]        byte_cnt_i,
    output logic                    req_ready_o,
    output logic                    rd_req_o,
    output logic [IDX_W-1:0]        rd_idx_o,
    input  logic                    rd_ack_i,
    input  logic [8*WORD_BYTES-1:0] rd_data_i,
    input  logic                    rd_err_i,
    output logic [8*WORD_BYTES-1:0] word_o,
    output logic [LANE_W-1:0]       lane_o,
    output logic                    emit_o,
    output logic                    emit_last_o,
    output logic                    done_o,
    output logic                    err_o,
    output logic [IDX_W-1:0]        words_left_o
);
    localparam logic [LANE_W-1:0] LANE_MAX = LANE_W'(WORD_BYTES - 1);

    bwr_state_e              state_q;
    logic [IDX_W-1:0]        idx_q;
    logic [IDX_W-1:0]        words_left_q;
    logic [CNT_W-1:0]        bytes_left_q;
    logic [LANE_W-1:0]       lane_q;
    logic [8*WORD_BYTES-1:0] word_q;
    logic                    done_q;
    logic                    err_q;

    // Main sequencer: idle -> fetch -> emit, looping back to fetch at each word end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= BWR_IDLE;
            idx_q        <= '0;
            words_left_q <= '0;
            bytes_left_q <= '0;
            lane_q       <= '0;
            word_q       <= '0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                BWR_IDLE: begin
                    if (req_valid_i) begin
                        if (span_ok_i) begin
                            state_q      <= BWR_FETCH;
                            idx_q        <= first_idx_i;
                            words_left_q <= word_cnt_i;
                            bytes_left_q <= byte_cnt_i;
                            lane_q       <= lane_i;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                BWR_FETCH: begin
                    if (rd_ack_i) begin
                        if (rd_err_i) begin
                            err_q   <= 1'b1;
                            state_q <= BWR_IDLE;
                        end else begin
                            word_q       <= rd_data_i;
                            words_left_q <= words_left_q - 1'b1;
                            state_q      <= BWR_EMIT;
                        end
                    end
                end
                BWR_EMIT: begin
                    bytes_left_q <= bytes_left_q - 1'b1;
                    if (bytes_left_q == CNT_W'(1)) begin
                        done_q  <= 1'b1;
                        state_q <= BWR_IDLE;
                    end else if (lane_q == LANE_MAX) begin
                        lane_q  <= '0;
                        idx_q   <= idx_q + 1'b1;
                        state_q <= BWR_FETCH;
                    end else begin
                        lane_q <= lane_q + 1'b1;
                    end
                end
                default: state_q <= BWR_IDLE;
            endcase
        end
    end

    // Decode outputs from the registered state.
    always_comb begin
        req_ready_o  = (state_q == BWR_IDLE);
        rd_req_o     = (state_q == BWR_FETCH);
        rd_idx_o     = idx_q;
        emit_o       = (state_q == BWR_EMIT);
        emit_last_o  = (state_q == BWR_EMIT) && (bytes_left_q == CNT_W'(1));
        word_o       = word_q;
        lane_o       = lane_q;
        done_o       = done_q;
        err_o        = err_q;
        words_left_o = words_left_q;
    end

endmodule

// File: rtl/byte_window_reader.sv
// Top: serves byte windows of a fixed region from a word-granular read port.
// Assumes: one request at a time; the word port is single outstanding.
module byte_window_reader #(
    parameter  int WORD_BYTES  = 4,
    parameter  int REGION_BASE = 96,
    parameter  int REGION_SIZE = 32,
    parameter  int ADDR_W      = 12,
    localparam int END_BYTES   = REGION_BASE + REGION_SIZE,
    localparam int IDX_W       = $clog2(END_BYTES / WORD_BYTES + 2),
    localparam int LANE_W      = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
    localparam int CNT_W       = $clog2(REGION_SIZE + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_offset,
    input  logic [ADDR_W-1:0]       req_size,
    output logic                    rd_req,
    output logic [IDX_W-1:0]        rd_idx,
    input  logic                    rd_ack,
    input  logic [8*WORD_BYTES-1:0] rd_data,
    input  logic                    rd_err,
    output logic                    out_valid,
    output logic [7:0]              out_byte,
    output logic                    out_last,
    output logic                    resp_done,
    output logic                    resp_err
);
    logic                    span_ok;
    logic [IDX_W-1:0]        first_idx;
    logic [IDX_W-1:0]        word_cnt;
    logic [LANE_W-1:0]       start_lane;
    logic [CNT_W-1:0]        byte_cnt;
    logic [8*WORD_BYTES-1:0] held_word;
    logic [LANE_W-1:0]       cur_lane;
    logic [IDX_W-1:0]        words_left;

    bwr_span_calc #(
        .WORD_BYTES (WORD_BYTES),
        .REGION_BASE(REGION_BASE),
        .REGION_SIZE(REGION_SIZE),
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .LANE_W     (LANE_W),
        .CNT_W      (CNT_W)
    ) u_span (
        .offset_i   (req_offset),
        .size_i     (req_size),
        .ok_o       (span_ok),
        .first_idx_o(first_idx),
        .word_cnt_o (word_cnt),
        .lane_o     (start_lane),
        .byte_cnt_o (byte_cnt)
    );

    bwr_fetch_ctrl #(
        .WORD_BYTES(WORD_BYTES),
        .IDX_W     (IDX_W),
        .LANE_W    (LANE_W),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .span_ok_i   (span_ok),
        .first_idx_i (first_idx),
        .word_cnt_i  (word_cnt),
        .lane_i      (start_lane),
        .byte_cnt_i  (byte_cnt),
        .req_ready_o (req_ready),
        .rd_req_o    (rd_req),
        .rd_idx_o    (rd_idx),
        .rd_ack_i    (rd_ack),
        .rd_data_i   (rd_data),
        .rd_err_i    (rd_err),
        .word_o      (held_word),
        .lane_o      (cur_lane),
        .emit_o      (out_valid),
        .emit_last_o (out_last),
        .done_o      (resp_done),
        .err_o       (resp_err),
        .words_left_o(words_left)
    );

    bwr_lane_mux #(
        .WORD_BYTES(WORD_BYTES),
        .LANE_W    (LANE_W)
    ) u_mux (
        .word_i(held_word),
        .lane_i(cur_lane),
        .byte_o(out_byte)
    );

endmodule

// File: rtl/byte_window_reader_chk.sv
// Protocol checker for byte_window_reader, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module byte_window_reader_chk #(
    parameter int WORD_BYTES  = 4,
    parameter int REGION_BASE = 96,
    parameter int REGION_SIZE = 32,
    parameter int IDX_W       = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_req,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rd_ack,
    input logic             rd_err,
    input logic             out_valid,
    input logic             out_last,
    input logic             resp_done,
    input logic             resp_err,
    input logic [IDX_W-1:0] words_left
);
    localparam logic [IDX_W-1:0] IDX_LO = IDX_W'(REGION_BASE / WORD_BYTES);
    localparam logic [IDX_W-1:0] IDX_HI =
        IDX_W'((REGION_BASE + REGION_SIZE + WORD_BYTES - 1) / WORD_BYTES);

    // R4
    idx_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_idx >= IDX_LO) && (rd_idx < IDX_HI));

    // R5
    word_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (words_left != '0));

    // R6
    last_is_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R7
    last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> resp_done);

    // R7
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_done && resp_err));

    // R8
    rd_fail_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && rd_err) |=> (resp_err && !out_valid && !rd_req));

    // R9
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || out_valid) |-> !req_ready);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_idx)));

    // R10
    rd_emit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && out_valid));

endmodule

bind byte_window_reader byte_window_reader_chk #(
    .WORD_BYTES (WORD_BYTES),
    .REGION_BASE(REGION_BASE),
    .REGION_SIZE(REGION_SIZE),
    .IDX_W      (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_req    (rd_req),
    .rd_idx    (rd_idx),
    .rd_ack    (rd_ack),
    .rd_err    (rd_err),
    .out_valid (out_valid),
    .out_last  (out_last),
    .resp_done (resp_done),
    .resp_err  (resp_err),
    .words_left(words_left)
);

// File: tb/byte_window_reader_bench.sv
// Scoreboard bench: the driver queues the expected bytes and responses,
// and the monitor compares them as the adapter produces them.
module byte_window_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WB    = 4;
    localparam int BASE  = 96;
    localparam int RSIZE = 32;
    localparam int AW    = 12;
    localparam int IW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_offset = '0;
    logic [AW-1:0] req_size = '0;
    logic          rd_req;
    logic [IW-1:0] rd_idx;
    logic          rd_ack = 1'b0;
    logic [31:0]   rd_data = '0;
    logic          rd_err = 1'b0;
    logic          out_valid;
    logic [7:0]    out_byte;
    logic          out_last;
    logic          resp_done;
    logic          resp_err;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int wait_cnt = 0;
    int err_idx = -1;
    int ends_seen = 0;
    int ends_exp = 0;
    bit finished = 1'b0;

    logic [8:0] exp_bytes[$];
    int         exp_end[$];
    string      exp_tag[$];
    int         rd_log[$];

    byte_window_reader #(
        .WORD_BYTES(WB), .REGION_BASE(BASE), .REGION_SIZE(RSIZE), .ADDR_W(AW)
    ) u_byte_window_reader (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_offset(req_offset), .req_size(req_size),
        .rd_req(rd_req), .rd_idx(rd_idx), .rd_ack(rd_ack),
        .rd_data(rd_data), .rd_err(rd_err),
        .out_valid(out_valid), .out_byte(out_byte), .out_last(out_last),
        .resp_done(resp_done), .resp_err(resp_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] mem_byte(input int addr);
        return 8'((addr * 7 + 3) ^ 8'hA5);
    endfunction

    function automatic logic [31:0] mem_word(input int idx);
        logic [31:0] w;
        for (int k = 0; k < WB; k++) w[k*8 +: 8] = mem_byte(idx * WB + k);
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Word store model: acknowledges a held read after lat+1 cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            rd_ack   <= 1'b0;
            wait_cnt <= 0;
        end else if (rd_req && !rd_ack) begin
            if (wait_cnt >= lat) begin
                rd_ack   <= 1'b1;
                rd_data  <= mem_word(int'(rd_idx));
                rd_err   <= (int'(rd_idx) == err_idx);
                wait_cnt <= 0;
                rd_log.push_back(int'(rd_idx));
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            rd_ack <= 1'b0;
            rd_err <= 1'b0;
        end
    end

    // Monitor: pops the expected bytes and responses on the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (exp_bytes.size() == 0) begin
                    check(1'b0, "R6", "unexpected byte", int'(out_byte), -1);
                end else begin
                    logic [8:0] e;
                    e = exp_bytes.pop_front();
                    check(out_byte == e[7:0], "R6", "byte value", int'(out_byte), int'(e[7:0]));
                    check(out_last == e[8], "R6", "last flag", int'(out_last), int'(e[8]));
                end
            end
            if (resp_done || resp_err) begin
                int code;
                code = resp_done ? 1 : 2;
                check(!(resp_done && resp_err), "R7", "done with err", 3, code);
                if (exp_end.size() == 0) begin
                    check(1'b0, "R9", "unexpected response", code, 0);
                end else begin
                    int e;
                    string t;
                    e = exp_end.pop_front();
                    t = exp_tag.pop_front();
                    check(code == e, t, "response kind (1 done, 2 err)", code, e);
                    check(exp_bytes.size() == 0, t, "bytes missing at response",
                          exp_bytes.size(), 0);
                end
                ends_seen++;
            end
        end
    end

    // Driver: computes the expectation, pulses the request, waits, checks reads.
    task automatic run_req(input int off, input int size, input int l,
                           input int eidx, input bit spurious);
        bit ok;
        int adj, first, bound, stop;
        int exp_reads[$];
        string tag;
        lat = l;
        err_idx = eidx;
        rd_log.delete();
        ok = (off >= 0) && (size > 0) && (off + size <= RSIZE);
        tag = (off < 0) ? "R1" : (size <= 0) ? "R2" : (!ok) ? "R3" : (eidx >= 0) ? "R8" : "R7";
        if (ok) begin
            adj = off + BASE;
            first = adj / WB;
            bound = (adj + size + WB - 1) / WB;
            stop = bound;
            if (eidx >= first && eidx < bound) stop = eidx + 1;
            for (int i = first; i < stop; i++) exp_reads.push_back(i);
            for (int a = adj; a < adj + size; a++) begin
                if (eidx >= first && eidx < bound && a / WB >= eidx) break;
                exp_bytes.push_back({(a == adj + size - 1) ? 1'b1 : 1'b0, mem_byte(a)});
            end
            exp_end.push_back((eidx >= first && eidx < bound) ? 2 : 1);
        end else begin
            exp_end.push_back(2);
        end
        exp_tag.push_back(tag);
        ends_exp++;
        @(negedge clk);
        check(req_ready == 1'b1, "R9", "ready while idle", int'(req_ready), 1);
        req_offset = AW'(off);
        req_size   = AW'(size);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (spurious) begin
            @(negedge clk);
            check(req_ready == 1'b0, "R9", "ready while busy", int'(req_ready), 0);
            req_offset = AW'(-1);
            req_size   = AW'(3);
            req_valid  = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (ends_seen < ends_exp) @(negedge clk);
        repeat (3) @(negedge clk);
        check(ends_seen == ends_exp, "R9", "response count", ends_seen, ends_exp);
        check(rd_log.size() == exp_reads.size(), ok ? "R5" : tag, "word read count",
              rd_log.size(), exp_reads.size());
        for (int i = 0; i < exp_reads.size() && i < rd_log.size(); i++)
            check(rd_log[i] == exp_reads[i], (i == 0) ? "R4" : "R5", "word index",
                  rd_log[i], exp_reads[i]);
        err_idx = -1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(req_ready == 1'b1, "R9", "reset ready", int'(req_ready), 1);
        check(!rd_req && !out_valid, "R10", "reset idle outputs", int'(rd_req) + int'(out_valid), 0);
        check(!resp_done && !resp_err, "R7", "reset responses", int'(resp_done) + int'(resp_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_req(0, 4, 0, -1, 1'b0);    // aligned single word
        run_req(1, 2, 1, -1, 1'b0);    // inside one word
        run_req(3, 6, 2, -1, 1'b0);    // three words, unaligned
        run_req(0, RSIZE, 0, -1, 1'b0); // R3 exact fit, whole region
        run_req(RSIZE - 1, 1, 1, -1, 1'b0);
        run_req(RSIZE - 1, 2, 0, -1, 1'b0); // R3 one past end
        run_req(-1, 2, 0, -1, 1'b0);   // R1
        run_req(4, 0, 0, -1, 1'b0);    // R2 zero
        run_req(4, -3, 0, -1, 1'b0);   // R2 negative
        run_req(2, 10, 1, 25, 1'b0);   // R8 mid-request failure
        run_req(6, 4, 0, 25, 1'b0);    // R8 failure on first word
        run_req(5, 7, 2, -1, 1'b1);    // R9 spurious request while busy
        run_req(9, 14, 0, -1, 1'b0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule